// File: doc/BRIEF.md
# Two-Way Storing Bus Register

This block moves an 18-bit word between two ports, A and B, in either direction. Each direction has its own storage register. The register can pass data straight through, hold it, or capture it on a rising edge of a per-direction strobe. Three controls govern each direction: a pass-through enable, a capture strobe and a drive enable. The drive enable is active high for A-to-B and active low for B-to-A.

Everything runs on one system clock. The capture strobes are sampled on that clock and compared with their previous sample to find rising edges. The block has no tri-state pins. Each port presents a data-out bus and a registered drive flag, and the surrounding logic uses the flag to decide whether the port is driven. No path inverts the data.

Top module: `bidir_store_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a rising `clk` edge) clears both stored words to zero and clears both drive flags. With the pass-through enables low, both data outputs then read zero.
- R2: While `ab_pass` is high, `b_out` equals `a_in` in the same cycle, and the A-to-B stored word takes `a_in` at every clock edge.
- R3: When `ab_pass` goes low, `b_out` keeps the `a_in` value sampled at the last clock edge at which `ab_pass` was high.
- R4: With `ab_pass` low, a clock edge at which `ab_strobe` is sampled high, after being sampled low at the edge before, loads `a_in` into the A-to-B word. `b_out` shows the new word from that edge onward.
- R5: With `ab_pass` low, a strobe that stays high, stays low or falls leaves the A-to-B word unchanged, whatever `a_in` does.
- R6: `b_drive` is high exactly one clock edge after `ab_drive_en` is sampled high (the drive enable is active high).
- R7: `a_drive` is high exactly one clock edge after `ba_drive_n` is sampled low (active low). Sampling it high gives `a_drive` low one edge later.
- R8: The B-to-A direction follows R2 to R5 using `ba_pass`, `ba_strobe`, `b_in` and `a_out`, and keeps its own word. Activity on the A-to-B controls never changes `a_out`, and activity on the B-to-A controls never changes `b_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Word received on port A |
| b_in | input | 18 | Word received on port B |
| ab_pass | input | 1 | A-to-B pass-through enable |
| ab_strobe | input | 1 | A-to-B capture strobe (rising edge) |
| ab_drive_en | input | 1 | A-to-B drive enable, active high |
| ba_pass | input | 1 | B-to-A pass-through enable |
| ba_strobe | input | 1 | B-to-A capture strobe (rising edge) |
| ba_drive_n | input | 1 | B-to-A drive enable, active low |
| b_out | output | 18 | Word presented on port B |
| b_drive | output | 1 | Port B driver on |
| a_out | output | 18 | Word presented on port A |
| a_drive | output | 1 | Port A driver on |

## Verification
A stored word that is wrong stays hidden while its pass-through enable is high. It appears on the data output in the first cycle after that enable drops, or in the cycle after a capture edge. The sequences therefore end each pass-through run with a drop of the enable, and they follow each capture with held and falling strobes while the input changes. A stale strobe sample would cause either a phantom load or a missed load, and either one shows on the output one edge after the strobe. A polarity error on a drive enable shows on the drive flag one edge after the enable changes.

// File: rtl/bidir_store_reg.sv
module bidir_store_reg #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_pass,
  input  logic         ab_strobe,
  input  logic         ab_drive_en,
  input  logic         ba_pass,
  input  logic         ba_strobe,
  input  logic         ba_drive_n,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic [W-1:0] a_out,
  output logic         a_drive
);

  logic [W-1:0] ab_word, ba_word;
  logic         ab_stb_q, ba_stb_q;
  logic         ab_rise, ba_rise;

  assign ab_rise = ab_strobe & ~ab_stb_q;
  assign ba_rise = ba_strobe & ~ba_stb_q;

  always_ff @(posedge clk) begin
    ab_stb_q <= ab_strobe;
    if (rst) begin
      ab_word <= '0;
      b_drive <= 1'b0;
    end else begin
      b_drive <= ab_drive_en;
      if (ab_pass || ab_rise) ab_word <= a_in;
    end
  end

  always_ff @(posedge clk) begin
    ba_stb_q <= ba_strobe;
    if (rst) begin
      ba_word <= '0;
      a_drive <= 1'b0;
    end else begin
      a_drive <= ~ba_drive_n;
      if (ba_pass || ba_rise) ba_word <= b_in;
    end
  end

  assign b_out = ab_pass ? a_in : ab_word;
  assign a_out = ba_pass ? b_in : ba_word;

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk)
    if (rst_q)
      p_reset_clear_r1: assert (ab_word == '0 && ba_word == '0 && !a_drive && !b_drive)
        else $error("reset did not clear state");

  p_pass_load_r2: assert property (@(posedge clk) disable iff (rst)
    ab_pass |=> ab_word == $past(a_in));

  p_edge_load_r4: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && ab_strobe && !$past(ab_strobe)) |=> ab_word == $past(a_in));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && !(ab_strobe && !$past(ab_strobe))) |=> $stable(ab_word));

  p_bhold_r8: assert property (@(posedge clk) disable iff (rst)
    (!ba_pass && !(ba_strobe && !$past(ba_strobe))) |=> $stable(ba_word));

  p_bdrive_r6: assert property (@(posedge clk) disable iff (rst)
    ab_drive_en |=> b_drive);

  p_adrive_r7: assert property (@(posedge clk) disable iff (rst)
    ba_drive_n |=> !a_drive);

endmodule

// File: tb/tb_bidir_store_reg.sv
`timescale 1ns/1ps
module tb_bidir_store_reg;
  localparam int W = 18;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_pass = 0, ab_strobe = 0, ab_drive_en = 0;
  logic ba_pass = 0, ba_strobe = 0, ba_drive_n = 1;
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive;

  bidir_store_reg #(.W(W)) dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_drive_en(ab_drive_en),
    .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
  );

  typedef struct {
    string        req;
    logic [W-1:0] eb;
    logic [W-1:0] ea;
    logic         ebd;
    logic         ead;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic cmp(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, logic [W-1:0] eb, logic [W-1:0] ea, logic ebd, logic ead);
    exp_t e;
    e.req = req; e.eb = eb; e.ea = ea; e.ebd = ebd; e.ead = ead;
    sb.push_back(e);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp(e.req, "b_out", b_out, e.eb);
        cmp(e.req, "a_out", a_out, e.ea);
        cmp(e.req, "b_drive", {{(W-1){1'b0}}, b_drive}, {{(W-1){1'b0}}, e.ebd});
        cmp(e.req, "a_drive", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, e.ead});
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    @(negedge clk);
    // R1: reset with strobes high must not leave a phantom edge
    rst = 1; ab_strobe = 1; ba_strobe = 1; a_in = 18'h3FFFF; b_in = 18'h3FFFF;
    step("R1", 18'h0, 18'h0, 0, 0);
    rst = 0;
    step("R1", 18'h0, 18'h0, 0, 0);
    ab_strobe = 0; ba_strobe = 0;
    step("R1", 18'h0, 18'h0, 0, 0);
    // R2, R6: pass-through, driver on
    ab_pass = 1; ab_drive_en = 1; a_in = 18'h12345;
    step("R2", 18'h12345, 18'h0, 1, 0);
    a_in = 18'h3ABCD;
    step("R2", 18'h3ABCD, 18'h0, 1, 0);
    // R3: drop pass-through, later A changes ignored
    ab_pass = 0; a_in = 18'h00F0F;
    step("R3", 18'h3ABCD, 18'h0, 1, 0);
    // R4: rising strobe loads
    ab_strobe = 1; a_in = 18'h15555;
    step("R4", 18'h15555, 18'h0, 1, 0);
    // R5: strobe held high
    a_in = 18'h2AAAA;
    step("R5", 18'h15555, 18'h0, 1, 0);
    // R5: strobe falls
    ab_strobe = 0; a_in = 18'h0FFFF;
    step("R5", 18'h15555, 18'h0, 1, 0);
    // R5: strobe held low
    a_in = 18'h00000;
    step("R5", 18'h15555, 18'h0, 1, 0);
    // R4, R6: second rising edge, driver off
    ab_strobe = 1; a_in = 18'h0FFFF; ab_drive_en = 0;
    step("R4", 18'h0FFFF, 18'h0, 0, 0);
    // R7, R8: B-to-A pass-through, driver on (active low)
    ba_drive_n = 0; ba_pass = 1; b_in = 18'h20001;
    step("R7", 18'h0FFFF, 18'h20001, 0, 1);
    ba_pass = 0; b_in = 18'h11111;
    step("R8", 18'h0FFFF, 18'h20001, 0, 1);
    ba_strobe = 1; b_in = 18'h30303;
    step("R8", 18'h0FFFF, 18'h30303, 0, 1);
    b_in = 18'h01010;
    step("R8", 18'h0FFFF, 18'h30303, 0, 1);
    ba_drive_n = 1;
    step("R7", 18'h0FFFF, 18'h30303, 0, 0);
    // R8: A-to-B activity leaves a_out alone
    ab_strobe = 0; a_in = 18'h00001;
    step("R8", 18'h0FFFF, 18'h30303, 0, 0);
    ab_strobe = 1;
    step("R8", 18'h00001, 18'h30303, 0, 0);
    ab_pass = 1; a_in = 18'h2F00F;
    step("R8", 18'h2F00F, 18'h30303, 0, 0);
    ab_pass = 0;
    // R1: mid-run reset
    rst = 1; ab_drive_en = 1; ba_drive_n = 0;
    step("R1", 18'h0, 18'h0, 0, 0);
    rst = 0; ab_drive_en = 0; ba_drive_n = 1;
    step("R1", 18'h0, 18'h0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule